// File: doc/BRIEF.md
# Receive Interrupt Moderation Timers

This block decides when a receive interrupt goes out. It uses two down-counting timers that are both started by packet-arrival pulses. Moderation trades a little latency for fewer interrupts.

The absolute timer starts with the first packet after an idle period. It sets an upper bound on how long that packet can wait. The delay timer is reloaded on every packet, so it fires only after a quiet gap in the traffic. When either timer expires, the block emits a one-cycle interrupt and returns both timers to idle.

Both timers count only on cycles where `tick_en` is high. The caller supplies that enable and so sets the time base. The two reload values are plain control inputs. They are sampled when a timer loads.

There is no data stream at this block's edge. Every pin is a plain control or status signal without a handshake.

Top module: `rx_irq_moderator`

## Requirements
- R1: When `pkt_rx` is high with the absolute timer idle and `abs_reload` = N (nonzero), the absolute timer loads N. With no other event, `irq` goes high in the cycle after the clock edge that sees the Nth tick following the arrival. With a tick on every cycle, that is N cycles after the arrival cycle.
- R2: Every `pkt_rx` with `dly_reload` = M (nonzero) reloads the delay timer to M, whether or not it is already running. With no other event, `irq` goes high M ticked cycles after the last arrival.
- R3: A `pkt_rx` while the absolute timer is running does not restart it. Its expiry time stays fixed by the first arrival.
- R4: An expiry of either timer produces one `irq` pulse and returns both timers to idle, so the other timer then produces no interrupt of its own.
- R5: With `abs_reload` = 0 the absolute timer never starts and never produces an interrupt.
- R6: With `dly_reload` = 0 each `pkt_rx` produces `irq` in the following cycle, and no timer is started by that arrival.
- R7: Timers decrement only on cycles with `tick_en` high. When ticks come every second cycle, an expiry takes twice as many cycles.
- R8: When a `pkt_rx` coincides with an expiry, the interrupt fires and the arrival restarts both timers.
- R9: When both timers expire in the same cycle, exactly one `irq` cycle results.
- R10: A low `rst_n` clears both timers and `irq`. A packet seen before the reset produces no interrupt after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_rx | input | 1 | One-cycle packet-arrival pulse |
| tick_en | input | 1 | Time-base enable; timers count only when high |
| abs_reload | input | CNT_W | Absolute timer start value; 0 disables it |
| dly_reload | input | CNT_W | Delay timer start value; 0 selects immediate interrupts |
| irq | output | 1 | Receive-timer interrupt, one cycle per firing |

## Verification
The bench drives the block with four kinds of traffic:
- A single packet, which separates absolute expiry from delay expiry depending on which reload value is smaller.
- Bursts of closely spaced packets, which show whether the delay timer restarts and the absolute timer holds.
- A packet that lands exactly on an expiry cycle, which shows the restart of both timers in the interrupt count.
- Equal reload values, whose simultaneous expiry must yield a single pulse.

Zero reload values are run to tell disabled and immediate behaviour apart. A sparse tick pattern is run to show that only enabled cycles are counted. A mid-run reset is run to show that pending state is discarded.

// File: rtl/rxim_pkg.sv
package rxim_pkg;
  localparam int CNT_W = 16;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/rxim_timer.sv
module rxim_timer #(
  parameter int W       = 16,
  parameter bit RESTART = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         clear,
  input  logic         tick,
  input  logic [W-1:0] reload,
  output logic         busy,
  output logic         expire
);
  logic [W-1:0] cnt;
  logic         do_load;

  // A non-restartable timer accepts a start only when idle or being cleared.
  generate
    if (RESTART) begin : g_restart
      assign do_load = start && (reload != '0);
    end else begin : g_hold
      assign do_load = start && (reload != '0) && (!busy || clear);
    end
  endgenerate

  assign expire = busy && tick && (cnt == W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (do_load) begin
      busy <= 1'b1;
      cnt  <= reload;
    end else if (clear) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy && tick) begin
      cnt <= cnt - W'(1);
    end
  end
endmodule

// File: rtl/rxim_fire.sv
module rxim_fire (
  input  logic clk,
  input  logic rst_n,
  input  logic abs_exp,
  input  logic dly_exp,
  input  logic immediate,
  output logic fire,
  output logic irq
);
  assign fire = abs_exp || dly_exp || immediate;

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= fire;
  end
endmodule

// File: rtl/rx_irq_moderator.sv
module rx_irq_moderator
  import rxim_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pkt_rx,
  input  logic         tick_en,
  input  logic [W-1:0] abs_reload,
  input  logic [W-1:0] dly_reload,
  output logic         irq
);
  logic immediate, arm, fire;
  logic abs_busy, abs_exp, dly_busy, dly_exp;

  assign immediate = pkt_rx && (dly_reload == '0);
  assign arm       = pkt_rx && !immediate;

  rxim_timer #(.W(W), .RESTART(1'b0)) u_abs (
    .clk(clk), .rst_n(rst_n), .start(arm), .clear(fire), .tick(tick_en),
    .reload(abs_reload), .busy(abs_busy), .expire(abs_exp));

  rxim_timer #(.W(W), .RESTART(1'b1)) u_dly (
    .clk(clk), .rst_n(rst_n), .start(arm), .clear(fire), .tick(tick_en),
    .reload(dly_reload), .busy(dly_busy), .expire(dly_exp));

  rxim_fire u_fire (
    .clk(clk), .rst_n(rst_n), .abs_exp(abs_exp), .dly_exp(dly_exp),
    .immediate(immediate), .fire(fire), .irq(irq));
endmodule

// File: rtl/rx_irq_moderator_chk.sv
module rx_irq_moderator_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pkt_rx,
  input logic         tick_en,
  input logic [W-1:0] abs_reload,
  input logic [W-1:0] dly_reload,
  input logic         irq,
  input logic         abs_busy,
  input logic         dly_busy
);
  AST_IMMEDIATE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_rx && dly_reload == '0) |=> irq); // R6
  AST_NO_TICK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !pkt_rx) |=> !irq); // R7
  AST_ABS_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (abs_reload == '0 && !abs_busy) |=> !abs_busy); // R5
  AST_FIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(pkt_rx)) |-> (!abs_busy && !dly_busy)); // R4
  AST_DLY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_rx && dly_reload != '0) |=> dly_busy); // R2
endmodule

bind rx_irq_moderator rx_irq_moderator_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_rx(pkt_rx), .tick_en(tick_en),
  .abs_reload(abs_reload), .dly_reload(dly_reload), .irq(irq),
  .abs_busy(abs_busy), .dly_busy(dly_busy));

// File: tb/rx_irq_moderator_bench.sv
module rx_irq_moderator_bench;
  localparam int W   = 16;
  localparam int WIN = 40;
  localparam logic [7:0] NONE = 8'hFF;

  typedef struct packed {
    logic [7:0] abs_v, dly_v, p0, p1, p2, p3, first, cnt;
  } vec_t;

  // abs, dly, packet cycles, expected first irq cycle, expected irq cycles
  localparam vec_t VECS [9] = '{
    '{8'd5,  8'd0, 8'd2, 8'd10, NONE, NONE, 8'd2,  8'd2}, // R6
    '{8'd0,  8'd4, 8'd3, NONE,  NONE, NONE, 8'd7,  8'd1}, // R2 R5
    '{8'd0,  8'd4, 8'd3, 8'd5,  8'd7, NONE, 8'd11, 8'd1}, // R2
    '{8'd6,  8'd4, 8'd0, 8'd2,  8'd4, 8'd6, 8'd6,  8'd2}, // R8
    '{8'd3,  8'd8, 8'd1, NONE,  NONE, NONE, 8'd4,  8'd1}, // R1 R4
    '{8'd4,  8'd4, 8'd0, NONE,  NONE, NONE, 8'd4,  8'd1}, // R9
    '{8'd10, 8'd3, 8'd0, NONE,  NONE, NONE, 8'd3,  8'd1}, // R4
    '{8'd0,  8'd0, 8'd1, 8'd2,  NONE, NONE, 8'd1,  8'd2}, // R6
    '{8'd8,  8'd6, 8'd0, 8'd3,  NONE, NONE, 8'd8,  8'd1}  // R3
  };

  logic clk = 1'b0, rst_n = 1'b0, pkt_rx = 1'b0, tick_en = 1'b0;
  logic [W-1:0] abs_reload = '0, dly_reload = '0;
  logic irq;
  int n_chk = 0, n_fail = 0;
  int first_c, irq_n;

  always #10 clk = ~clk;

  rx_irq_moderator #(.W(W)) u_rx_irq_moderator (
    .clk(clk), .rst_n(rst_n), .pkt_rx(pkt_rx), .tick_en(tick_en),
    .abs_reload(abs_reload), .dly_reload(dly_reload), .irq(irq));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pkt_rx = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_vec(input vec_t v);
    abs_reload = W'(v.abs_v); dly_reload = W'(v.dly_v);
    first_c = -1; irq_n = 0;
    for (int c = 0; c < WIN; c++) begin
      @(negedge clk);
      pkt_rx = (c == int'(v.p0)) || (c == int'(v.p1)) ||
               (c == int'(v.p2)) || (c == int'(v.p3));
      tick_en = 1'b1;
      @(posedge clk); #1;
      if (irq) begin
        irq_n++;
        if (first_c < 0) first_c = c;
      end
    end
    @(negedge clk); pkt_rx = 1'b0;
  endtask

  initial begin
    #5ms;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    #1 check("R10 reset irq", int'(irq), 0);

    foreach (VECS[i]) begin
      do_reset();
      run_vec(VECS[i]);
      check($sformatf("R1-vector%0d first irq (R2 R3 R4 R6 R8)", i), first_c, int'(VECS[i].first));
      check($sformatf("R9 vector%0d irq count", i), irq_n, int'(VECS[i].cnt));
    end

    // R7: ticks only on odd cycles, delay 3, packet at cycle 0 -> irq at cycle 5
    do_reset();
    abs_reload = '0; dly_reload = W'(3);
    first_c = -1; irq_n = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      pkt_rx = (c == 0);
      tick_en = (c % 2 == 1);
      @(posedge clk); #1;
      if (irq) begin
        irq_n++;
        if (first_c < 0) first_c = c;
      end
    end
    check("R7 gated first irq", first_c, 5);
    check("R7 gated irq count", irq_n, 1);

    // R10: packet, then reset mid-run, then no interrupt
    do_reset();
    abs_reload = W'(4); dly_reload = W'(5);
    @(negedge clk); pkt_rx = 1'b1; tick_en = 1'b1;
    @(negedge clk); pkt_rx = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    irq_n = 0;
    for (int c = 0; c < 15; c++) begin
      @(posedge clk); #1;
      if (irq) irq_n++;
    end
    check("R10 no irq after mid-run reset", irq_n, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule